// File: doc/BRIEF.md
# RMII Transmit Serializer (MAC side)

This block sits on the MAC side of a 100 Mb/s reduced media-independent link. It takes frame bytes from an upstream source over a valid/ready/last byte stream. For each frame it emits a preamble, a start-of-frame delimiter and then the payload, one 2-bit symbol per reference clock, on a transmit-enable / 2-bit data pair. After each frame it enforces an inter-packet gap before it will start the next one.

The link has no collision pin. For half-duplex operation the block therefore rebuilds a collision indication from its own transmit enable and the receive carrier-sense/data-valid input from the PHY. A mode input turns this detection off for full duplex. If the source runs dry in the middle of a frame, the frame is not cut short. The block keeps transmit enable high, sends idle symbols until data returns, and sets an error flag that stays set.

Top module: `rmii_tx_serializer`

## Requirements
- R1: After reset, tx_en, txd, s_ready, collision and underrun are all 0.
- R2: Each frame starts with 28 symbols of 2'b01 (seven 0x55 bytes), followed by the delimiter 0xD5 as the symbols 01,01,01,11. Every byte, including payload bytes, is sent least-significant bit pair first, one symbol per clock.
- R3: tx_en rises on the same clock as the first preamble symbol. It stays high for every symbol of the frame and falls on the clock right after the last payload symbol. A frame of N bytes therefore keeps tx_en high for exactly 32+4N clocks when no underrun occurs.
- R4: Whenever tx_en is low, txd is 2'b00, whatever the source presents.
- R5: When the next frame is already waiting, tx_en stays low for exactly IPG_CLKS+1 clocks (49 by default) between frames, and never for fewer than IPG_CLKS.
- R6: With full_duplex low, collision is high exactly while tx_en and crs_dv are both high.
- R7: With full_duplex high, collision stays low.
- R8: collision is never raised while tx_en is low. No pulse follows the end of a transmission.
- R9: The first payload byte is requested only on the last delimiter symbol. Each later byte is requested on the last symbol of the byte before it. No byte is requested after the byte marked last.
- R10: If no byte is available when one is requested inside a frame, tx_en stays high and txd sends 2'b00 until a byte arrives. The underrun flag is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 8 | Frame byte from the source |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | The byte is the final one of its frame |
| s_ready | output | 1 | The byte is taken at this clock edge |
| full_duplex | input | 1 | 1 disables collision detection |
| crs_dv | input | 1 | Receive carrier sense/data valid from the PHY |
| tx_en | output | 1 | Transmit enable toward the PHY |
| txd | output | 2 | Transmit symbol toward the PHY |
| collision | output | 1 | Regenerated half-duplex collision |
| underrun | output | 1 | Sticky source-starvation error |

## Verification
The hardest state to reach is a starved frame. The source has to stop in the middle of a frame, exactly when a byte is requested, and then resume without tx_en dropping. The bench sends one byte, holds s_valid low for several byte times, then supplies the rest. It checks that tx_en rose only once, that underrun stays set across a later clean frame, and that reset clears it. Back-to-back frames are built by presenting the next frame's first byte while the current frame is still being sent, so that the gap length can be measured exactly.

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int PRE_BYTES = 7,
  parameter int IPG_CLKS  = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       full_duplex,
  input  logic       crs_dv,
  output logic       tx_en,
  output logic [1:0] txd,
  output logic       collision,
  output logic       underrun
);
  localparam int BW = $clog2(PRE_BYTES + 1);
  localparam int GW = $clog2(IPG_CLKS + 1);
  localparam logic [BW-1:0] SFD_IDX = BW'(PRE_BYTES);
  localparam logic [BW-1:0] LAST_PRE = BW'(PRE_BYTES - 1);
  localparam logic [GW-1:0] GAP_END = GW'(IPG_CLKS - 1);

  typedef enum logic [1:0] {IDLE, PRE, DATA, GAP} st_t;

  st_t st;
  logic [7:0] sh;
  logic [1:0] sym;
  logic [BW-1:0] bidx;
  logic [GW-1:0] gcnt;
  logic last_q, starve, urun;

  wire sym_end = (sym == 2'd3);
  wire pre_end = (st == PRE) && sym_end && (bidx == SFD_IDX);

  assign s_ready   = pre_end || ((st == DATA) && (starve || (sym_end && !last_q)));
  assign tx_en     = (st == PRE) || (st == DATA);
  assign txd       = (tx_en && !starve) ? sh[1:0] : 2'b00;
  assign collision = !full_duplex && tx_en && crs_dv;
  assign underrun  = urun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; sh <= '0; sym <= '0; bidx <= '0; gcnt <= '0;
      last_q <= 1'b0; starve <= 1'b0; urun <= 1'b0;
    end else begin
      case (st)
        IDLE: if (s_valid) begin
          st <= PRE; sh <= 8'h55; sym <= '0; bidx <= '0;
        end
        PRE: begin
          sym <= sym + 2'd1;
          sh  <= sh >> 2;
          if (sym_end) begin
            if (bidx == SFD_IDX) begin
              st <= DATA;
              if (s_valid) begin
                sh <= s_data; last_q <= s_last;
              end else begin
                starve <= 1'b1; urun <= 1'b1;
              end
            end else begin
              bidx <= bidx + 1'b1;
              sh   <= (bidx == LAST_PRE) ? 8'hD5 : 8'h55;
            end
          end
        end
        DATA: begin
          if (starve) begin
            if (s_valid) begin
              sh <= s_data; last_q <= s_last; starve <= 1'b0; sym <= '0;
            end
          end else begin
            sym <= sym + 2'd1;
            sh  <= sh >> 2;
            if (sym_end) begin
              if (last_q) begin
                st <= GAP; gcnt <= '0; last_q <= 1'b0;
              end else if (s_valid) begin
                sh <= s_data; last_q <= s_last;
              end else begin
                starve <= 1'b1; urun <= 1'b1;
              end
            end
          end
        end
        GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GAP_END) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module rmii_tx_serializer_chk #(
  parameter int IPG_CLKS = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       full_duplex,
  input logic       crs_dv,
  input logic       tx_en,
  input logic [1:0] txd,
  input logic       collision,
  input logic       underrun
);
  logic [15:0] lowcnt;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt <= '0; seen <= 1'b0;
    end else begin
      if (tx_en) begin
        lowcnt <= '0; seen <= 1'b1;
      end else if (lowcnt != 16'hFFFF) begin
        lowcnt <= lowcnt + 16'd1;
      end
    end
  end

  // R4
  idle_txd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |-> txd == 2'b00);
  // R2
  first_sym_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_en) |-> txd == 2'b01);
  // R5
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) ($rose(tx_en) && seen) |-> lowcnt >= 16'(IPG_CLKS));
  // R7
  fd_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n) full_duplex |-> !collision);
  // R8
  col_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n) collision |-> (tx_en && crs_dv));
  // R10
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) underrun |=> underrun);
endmodule

bind rmii_tx_serializer rmii_tx_serializer_chk #(.IPG_CLKS(IPG_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs_dv(crs_dv),
  .tx_en(tx_en), .txd(txd), .collision(collision), .underrun(underrun)
);

// File: tb/sim_rmii_tx_serializer.sv
module sim_rmii_tx_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_valid = 1'b0, s_last = 1'b0, full_duplex = 1'b0, crs_dv = 1'b0;
  logic s_ready, tx_en, collision, underrun;
  logic [1:0] txd;

  int checks = 0, errors = 0;
  logic [1:0] cap [0:1023];
  int ncap = 0, rises = 0, lowrun = 0, last_gap = 0, idle_bad = 0, col_bad = 0;
  logic prev_en = 1'b0;
  logic [7:0] fb [0:15];

  always #5 clk = ~clk;

  rmii_tx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .full_duplex(full_duplex), .crs_dv(crs_dv), .tx_en(tx_en),
    .txd(txd), .collision(collision), .underrun(underrun)
  );

  always @(negedge clk) if (rst_n) begin
    if (tx_en) begin
      if (ncap < 1024) cap[ncap] = txd;
      ncap = ncap + 1;
      if (!prev_en) begin rises = rises + 1; last_gap = lowrun; end
      lowrun = 0;
    end else begin
      lowrun = lowrun + 1;
      if (txd != 2'b00) idle_bad = idle_bad + 1;
      if (collision) col_bad = col_bad + 1;
    end
    prev_en = tx_en;
  end

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int n, input int stall_after);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == stall_after && i != 0) begin
        s_valid = 1'b0;
        repeat (12) @(negedge clk);
      end
      s_valid = 1'b1; s_data = fb[i]; s_last = (i == n - 1);
      while (!s_ready && !(u0.st == 2'd0)) @(negedge clk);
      if (!s_ready) while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_data = 8'hFF; s_last = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_en) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int n, input int base);
    logic [1:0] exp;
    int bad = 0;
    for (int k = 0; k < 32 + 4 * n; k++) begin
      if (k < 28) exp = 2'b01;
      else if (k < 32) exp = (k == 31) ? 2'b11 : 2'b01;
      else exp = 2'((fb[(k - 32) / 4] >> (2 * ((k - 32) % 4))) & 8'h03);
      if (cap[base + k] != exp) bad = bad + 1;
    end
    chk(req, bad == 0, bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 tx_en", tx_en == 1'b0, tx_en, 0);
    chk("R1 txd", txd == 2'b00, txd, 0);
    chk("R1 s_ready", s_ready == 1'b0, s_ready, 0);
    chk("R1 flags", {collision, underrun} == 2'b00, {collision, underrun}, 0);
  endtask

  task automatic t_frame(input int n, input byte seed);
    int base = ncap;
    for (int i = 0; i < n; i++) fb[i] = 8'(seed * (i + 3) + i);
    push(n, -1);
    wait_idle();
    chk("R3 length", ncap - base == 32 + 4 * n, ncap - base, 32 + 4 * n);
    check_frame("R2 R9 symbols", n, base);
  endtask

  task automatic t_idle_junk();
    @(negedge clk);
    s_data = 8'hFF; s_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 idle txd", txd == 2'b00 && !tx_en, txd, 0);
    chk("R4 idle count", idle_bad == 0, idle_bad, 0);
  endtask

  task automatic t_back_to_back();
    int r0 = rises;
    for (int i = 0; i < 3; i++) fb[i] = 8'hA0 + 8'(i);
    push(3, -1);
    push(3, -1);
    wait_idle();
    chk("R5 frames", rises - r0 == 2, rises - r0, 2);
    chk("R5 gap", last_gap == 49, last_gap, 49);
  endtask

  task automatic t_collision();
    for (int i = 0; i < 4; i++) fb[i] = 8'h3C;
    full_duplex = 1'b0;
    fork
      push(4, -1);
      begin
        @(negedge clk);
        while (!tx_en) @(negedge clk);
        repeat (3) @(negedge clk);
        #1 chk("R6 no rx", collision == 1'b0, collision, 0);
        crs_dv = 1'b1;
        #1 chk("R6 both active", collision == 1'b1, collision, 1);
        full_duplex = 1'b1;
        #1 chk("R7 full duplex", collision == 1'b0, collision, 0);
        full_duplex = 1'b0;
        #1 chk("R6 restore", collision == 1'b1, collision, 1);
        while (tx_en) @(negedge clk);
        #1 chk("R8 after tx", collision == 1'b0, collision, 0);
        repeat (20) @(negedge clk);
        chk("R8 no pulse", col_bad == 0, col_bad, 0);
        crs_dv = 1'b0;
      end
    join
    wait_idle();
  endtask

  task automatic t_ready_timing();
    int cyc = 0;
    fb[0] = 8'h11; fb[1] = 8'h22;
    @(negedge clk);
    s_valid = 1'b1; s_data = fb[0]; s_last = 1'b0;
    @(negedge clk);
    while (!s_ready) begin cyc = cyc + 1; @(negedge clk); end
    chk("R9 first request", cyc == 31, cyc, 31);
    @(negedge clk);
    s_data = fb[1]; s_last = 1'b1; cyc = 0;
    while (!s_ready) begin cyc = cyc + 1; @(negedge clk); end
    chk("R9 next request", cyc == 3, cyc, 3);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    cyc = 0;
    repeat (8) begin if (s_ready) cyc = cyc + 1; @(negedge clk); end
    chk("R9 none after last", cyc == 0, cyc, 0);
    wait_idle();
  endtask

  task automatic t_underrun();
    int r0 = rises;
    for (int i = 0; i < 4; i++) fb[i] = 8'hE7 - 8'(i);
    chk("R10 clear before", underrun == 1'b0, underrun, 0);
    push(4, 1);
    wait_idle();
    chk("R10 flag", underrun == 1'b1, underrun, 1);
    chk("R10 tx_en held", rises - r0 == 1, rises - r0, 1);
    t_frame(2, 8'h5A);
    chk("R10 sticky", underrun == 1'b1, underrun, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R10 reset clears", underrun == 1'b0, underrun, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_frame(4, 8'h1D);
    t_frame(1, 8'hC3);
    t_frame(9, 8'h47);
    t_idle_junk();
    t_back_to_back();
    t_collision();
    t_ready_timing();
    t_underrun();
    chk("R4 final idle", idle_bad == 0, idle_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks = checks + 1; errors = errors + 1;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule